// File: doc/BRIEF.md
# Two-Port Station Learning Table

This block is the shared address-learning and forwarding-decision unit of a two-port Ethernet switch. Each port presents a request for every incoming frame. The request carries the frame's destination and source MAC addresses. A round-robin arbiter accepts one request per cycle. The winning destination is looked up in a hashed table held in internal synchronous RAM. The unit then reports whether the frame goes to the opposite port or is dropped.

In the same pass, the frame's source address is written into the table along with the port it arrived on. Later frames addressed to that station are therefore steered correctly. A station seen only on the port a frame came from is local to that segment, so such frames are discarded. Everything else crosses to the other port. There is one table for both ports. Each hash bucket holds one entry.

Top module: `mlt_learn_table`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rsp_valid` is low. After reset the table is empty, so the first lookup reports `rsp_known`=0 and `rsp_fwd`=1.
- R2: At most one bit of `req_grant` is high in any cycle, and only for a port whose `req_valid` is high. A port that requests alone is granted in that same cycle.
- R3: When both ports request in the same cycle, the grant goes to the port not granted most recently. The first contested grant after reset goes to port 0.
- R4: A request granted in cycle c gives `rsp_valid` high for one cycle in cycle c+2, with `rsp_port` equal to the granted port (port 0 = bit 0 of the request vectors, low 48 bits of the address buses).
- R5: A 48-bit address maps to a table slot given by the low `IDX_W` bits of a CRC-8. The CRC uses polynomial x^8+x^2+x+1 (0x07) and starts from zero. It shifts in address bit 47 first, down to bit 0, with no reflection and no final inversion.
- R6: Every granted request writes its source address and arrival port into its slot, marking the slot valid. A later lookup of that address reports `rsp_known`=1.
- R7: A frame whose destination is known and recorded on the port the frame arrived on is dropped (`rsp_fwd`=0).
- R8: A frame whose destination is known on the other port is forwarded (`rsp_fwd`=1).
- R9: A frame whose destination is not in the table is forwarded with `rsp_known`=0.
- R10: A destination with the group bit (bit 40) set, including all-ones broadcast, is always forwarded, even if that address sits in the table on the arrival port.
- R11: When a new source address hashes to a slot holding a different address, it replaces that entry. The old address then looks up as unknown.
- R12: A lookup granted in the cycle right after another grant sees the source learned by that earlier grant.
- R13: A source address seen again on the other port moves its entry to that port.
- R14: A frame's lookup uses the table as it stood before that frame's own source is learned, so a frame whose destination equals its own new source is reported unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-port lookup request, held until granted |
| req_dst | input | 96 | Destination addresses, port 0 in bits 47:0 |
| req_src | input | 96 | Source addresses, port 0 in bits 47:0 |
| req_grant | output | 2 | One-hot acceptance of a request this cycle |
| rsp_valid | output | 1 | Decision valid |
| rsp_port | output | 1 | Port whose request the decision belongs to |
| rsp_fwd | output | 1 | 1 = send to the other port, 0 = drop |
| rsp_known | output | 1 | Destination matched a valid table entry |

## Verification
The bench sends back-to-back requests whose second lookup targets the source learned by the first. A table without write-to-read bypass would read a stale slot and forward instead of dropping. It builds a pair of addresses that share a slot, using the stated CRC. A design with a different hash or a bucket that failed to overwrite would still report the evicted station as known. It holds both ports requesting for several cycles, so an arbiter that favours one port or never moves its pointer shows a repeated grant. It also sends a frame whose destination equals its own source, and a group address learned on the arrival port. These catch a lookup that reads after its own write, and a group address that is wrongly dropped.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    localparam int MAC_W = 48;
    localparam int NPORT = 2;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam int GROUP_BIT = 40;

    typedef logic [MAC_W-1:0] mac_t;

    typedef struct packed {
        logic vld;
        mac_t mac;
        logic port;
    } entry_t;

    typedef struct packed {
        logic port;
        mac_t dst;
        mac_t src;
    } lookup_t;

    typedef enum logic {
        ACT_DROP = 1'b0,
        ACT_FWD  = 1'b1
    } act_e;

    // Bitwise CRC, most significant address bit shifted in first
    function automatic logic [CRC_W-1:0] mac_crc(mac_t a);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = MAC_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ a[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic logic is_group(mac_t a);
        return a[GROUP_BIT];
    endfunction

endpackage

// File: rtl/mlt_rr_arb.sv
module mlt_rr_arb
    import mlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] gnt
);

    // last = index of the port granted most recently
    logic last_q;

    always_comb begin
        if (req == 2'b11) begin
            gnt = last_q ? 2'b01 : 2'b10;
        end else begin
            gnt = req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b1;
        end else if (|gnt) begin
            last_q <= gnt[1];
        end
    end

endmodule

// File: rtl/mlt_hash.sv
module mlt_hash
    import mlt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  mac_t             mac,
    output logic [IDX_W-1:0] idx
);

    assign idx = IDX_W'(mac_crc(mac));

endmodule

// File: rtl/mlt_table_ram.sv
module mlt_table_ram
    import mlt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output entry_t           rdata,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  entry_t           wdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    mac_t             mac_q  [DEPTH];
    logic             port_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[waddr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mac_q[waddr]  <= wdata.mac;
            port_q[waddr] <= wdata.port;
        end
    end

    // Registered read; a write to the same slot in the same cycle is passed through
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            if (we && (waddr == raddr)) begin
                rdata <= wdata;
            end else begin
                rdata.vld  <= vld_q[raddr];
                rdata.mac  <= mac_q[raddr];
                rdata.port <= port_q[raddr];
            end
        end
    end

endmodule

// File: rtl/mlt_learn_table.sv
module mlt_learn_table
    import mlt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORT-1:0]       req_valid,
    input  logic [NPORT*MAC_W-1:0] req_dst,
    input  logic [NPORT*MAC_W-1:0] req_src,
    output logic [NPORT-1:0]       req_grant,
    output logic                   rsp_valid,
    output logic                   rsp_port,
    output logic                   rsp_fwd,
    output logic                   rsp_known
);

    mac_t in_dst [NPORT];
    mac_t in_src [NPORT];

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_unpack
        assign in_dst[gi] = req_dst[gi*MAC_W +: MAC_W];
        assign in_src[gi] = req_src[gi*MAC_W +: MAC_W];
    end

    // Arbitration
    mlt_rr_arb u_arb (
        .clk (clk),
        .rst (rst),
        .req (req_valid),
        .gnt (req_grant)
    );

    logic    win_port;
    logic    win_any;
    lookup_t win_req;

    assign win_any  = |req_grant;
    assign win_port = req_grant[1];
    assign win_req  = '{port: win_port, dst: in_dst[win_port], src: in_src[win_port]};

    // Stage 1: granted request held while the table read completes
    lookup_t s1_q;
    logic    s1_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld_q <= 1'b0;
            s1_q     <= '0;
        end else begin
            s1_vld_q <= win_any;
            if (win_any) s1_q <= win_req;
        end
    end

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    entry_t           rd_ent;
    entry_t           wr_ent;

    mlt_hash #(.IDX_W(IDX_W)) u_hash_dst (
        .mac (win_req.dst),
        .idx (rd_idx)
    );

    mlt_hash #(.IDX_W(IDX_W)) u_hash_src (
        .mac (s1_q.src),
        .idx (wr_idx)
    );

    assign wr_ent = '{vld: 1'b1, mac: s1_q.src, port: s1_q.port};

    mlt_table_ram #(.IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .re    (win_any),
        .raddr (rd_idx),
        .rdata (rd_ent),
        .we    (s1_vld_q),
        .waddr (wr_idx),
        .wdata (wr_ent)
    );

    // Decision
    logic hit;
    act_e act;

    always_comb begin
        hit = rd_ent.vld && (rd_ent.mac == s1_q.dst);
        if (!is_group(s1_q.dst) && hit && (rd_ent.port == s1_q.port)) begin
            act = ACT_DROP;
        end else begin
            act = ACT_FWD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_port  <= 1'b0;
            rsp_fwd   <= 1'b0;
            rsp_known <= 1'b0;
        end else begin
            rsp_valid <= s1_vld_q;
            if (s1_vld_q) begin
                rsp_port  <= s1_q.port;
                rsp_fwd   <= (act == ACT_FWD);
                rsp_known <= hit;
            end
        end
    end

endmodule

// File: rtl/mlt_learn_table_chk.sv
module mlt_learn_table_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] req_valid,
    input logic [1:0] req_grant,
    input logic       rsp_valid,
    input logic       rsp_port,
    input logic       rsp_fwd,
    input logic       rsp_known
);

    logic [1:0] prev_gnt;
    logic       g_d1, g_d2;
    logic       p_d1, p_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_gnt <= 2'b00;
            g_d1 <= 1'b0;
            g_d2 <= 1'b0;
            p_d1 <= 1'b0;
            p_d2 <= 1'b0;
        end else begin
            prev_gnt <= req_grant;
            g_d1 <= |req_grant;
            g_d2 <= g_d1;
            p_d1 <= req_grant[1];
            p_d2 <= p_d1;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant)); // R2

    AST_GRANT_ONLY_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_grant & ~req_valid) == 2'b00); // R2

    AST_RR_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid == 2'b11 && prev_gnt != 2'b00) |-> (req_grant != prev_gnt)); // R3

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == g_d2); // R4

    AST_RSP_PORT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_port == p_d2)); // R4

    AST_DROP_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fwd) |-> rsp_known); // R7

endmodule

bind mlt_learn_table mlt_learn_table_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_grant (req_grant),
    .rsp_valid (rsp_valid),
    .rsp_port  (rsp_port),
    .rsp_fwd   (rsp_fwd),
    .rsp_known (rsp_known)
);

// File: tb/mlt_learn_table_test.sv
module mlt_learn_table_test;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  req_valid;
    logic [95:0] req_dst;
    logic [95:0] req_src;
    logic [1:0]  req_grant;
    logic        rsp_valid, rsp_port, rsp_fwd, rsp_known;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlt_learn_table #(.IDX_W(IDX_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_dst   (req_dst),
        .req_src   (req_src),
        .req_grant (req_grant),
        .rsp_valid (rsp_valid),
        .rsp_port  (rsp_port),
        .rsp_fwd   (rsp_fwd),
        .rsp_known (rsp_known)
    );

    // Slot index per R5
    function automatic int slot_of(logic [47:0] a);
        logic [7:0] r;
        logic t;
        r = 8'h00;
        for (int k = 47; k >= 0; k--) begin
            t = r[7] ^ a[k];
            r = {r[6:0], 1'b0} ^ (t ? 8'h07 : 8'h00);
        end
        return int'(r) % (1 << IDX_W);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // One lone request, checked through grant and response (R2, R4)
    task automatic lookup(input int p, input logic [47:0] dst, input logic [47:0] src,
                          input logic exp_fwd, input logic exp_known, input string tag);
        logic [1:0] eg;
        eg = 2'b01 << p;
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_dst[p*48 +: 48] = dst;
        req_src[p*48 +: 48] = src;
        #1;
        chk({tag, " R2 grant"}, 64'(req_grant), 64'(eg));
        @(negedge clk);
        req_valid[p] = 1'b0;
        chk({tag, " R4 not early"}, 64'(rsp_valid), 64'd1 - 64'd1);
        @(negedge clk);
        chk({tag, " R4 valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " R4 port"}, 64'(rsp_port), 64'(p));
        chk({tag, " fwd"}, 64'(rsp_fwd), 64'(exp_fwd));
        chk({tag, " known"}, 64'(rsp_known), 64'(exp_known));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 2'b01;
        req_dst[47:0] = 48'h0200_0000_0001;
        req_src[47:0] = 48'h0200_0000_0002;
        repeat (3) begin
            @(negedge clk);
            chk("R1 rsp low in reset", 64'(rsp_valid), 64'd0);
        end
        rst = 1'b0;
        req_valid = 2'b00;
        @(negedge clk);
        chk("R1 rsp low after reset", 64'(rsp_valid), 64'd0);
        lookup(0, 48'h0200_0000_0002, 48'h0200_0000_0003, 1'b1, 1'b0, "R1 empty table");
    endtask

    task automatic t_learn_decide();
        do_reset();
        lookup(0, 48'h0200_0000_00AA, 48'h0200_0000_1111, 1'b1, 1'b0, "R9 unknown dst");
        lookup(0, 48'h0200_0000_1111, 48'h0200_0000_2222, 1'b0, 1'b1, "R7 R6 same-port drop");
        lookup(1, 48'h0200_0000_1111, 48'h0200_0000_3333, 1'b1, 1'b1, "R8 other-port fwd");
        lookup(0, 48'h0200_0000_3333, 48'h0200_0000_2222, 1'b1, 1'b1, "R8 learned on port1");
        lookup(1, 48'h0200_00AB_CDEF, 48'h0200_0000_3333, 1'b1, 1'b0, "R9 unknown from port1");
    endtask

    task automatic t_group();
        do_reset();
        lookup(0, 48'h0200_0000_0001, 48'h0100_5E00_0001, 1'b1, 1'b0, "R10 learn group src");
        lookup(0, 48'h0100_5E00_0001, 48'h0200_0000_0004, 1'b1, 1'b1, "R10 group dst fwd");
        lookup(0, 48'hFFFF_FFFF_FFFF, 48'h0200_0000_0004, 1'b1, 1'b0, "R10 broadcast fwd");
    endtask

    task automatic t_move();
        do_reset();
        lookup(0, 48'h0200_0000_0010, 48'h0200_0000_7777, 1'b1, 1'b0, "R13 learn p0");
        lookup(1, 48'h0200_0000_0011, 48'h0200_0000_7777, 1'b1, 1'b0, "R13 relearn p1");
        lookup(1, 48'h0200_0000_7777, 48'h0200_0000_0012, 1'b0, 1'b1, "R13 moved drop");
        lookup(0, 48'h0200_0000_7777, 48'h0200_0000_0013, 1'b1, 1'b1, "R13 moved fwd");
    endtask

    task automatic t_collision();
        logic [47:0] a, b;
        a = 48'h0200_1234_5678;
        b = a;
        for (int k = 1; k < 4096; k++) begin
            if (slot_of(a + 48'(k)) == slot_of(a)) begin
                b = a + 48'(k);
                break;
            end
        end
        chk("R5 found colliding pair", 64'(b != a), 64'd1);
        do_reset();
        lookup(0, 48'h0200_0000_0020, a, 1'b1, 1'b0, "R11 learn a");
        lookup(1, a, 48'h0200_0000_0021, 1'b1, 1'b1, "R11 a present");
        lookup(1, 48'h0200_0000_0022, b, 1'b1, 1'b0, "R11 learn b");
        lookup(0, a, 48'h0200_0000_0023, 1'b1, 1'b0, "R11 R5 a evicted");
        lookup(0, b, 48'h0200_0000_0023, 1'b1, 1'b1, "R11 b present");
    endtask

    task automatic t_self();
        do_reset();
        lookup(0, 48'h0200_0000_5555, 48'h0200_0000_5555, 1'b1, 1'b0, "R14 own src unseen");
        lookup(0, 48'h0200_0000_5555, 48'h0200_0000_0030, 1'b0, 1'b1, "R14 then learned");
    endtask

    task automatic t_back_to_back();
        do_reset();
        @(negedge clk);
        req_valid = 2'b01;
        req_dst[47:0] = 48'h0200_0000_0040;
        req_src[47:0] = 48'h0200_0000_9999;
        @(negedge clk);
        req_dst[47:0] = 48'h0200_0000_9999;
        req_src[47:0] = 48'h0200_0000_0041;
        #1;
        chk("R12 second grant", 64'(req_grant), 64'd1);
        @(negedge clk);
        req_valid = 2'b00;
        chk("R12 first valid", 64'(rsp_valid), 64'd1);
        chk("R12 first fwd", 64'(rsp_fwd), 64'd1);
        @(negedge clk);
        chk("R12 second valid", 64'(rsp_valid), 64'd1);
        chk("R12 second drop", 64'(rsp_fwd), 64'd0);
        chk("R12 second known", 64'(rsp_known), 64'd1);
    endtask

    task automatic t_round_robin();
        do_reset();
        @(negedge clk);
        req_valid = 2'b11;
        req_dst = {48'h0200_0000_0051, 48'h0200_0000_0050};
        req_src = {48'h0200_0000_0061, 48'h0200_0000_0060};
        #1;
        chk("R3 first to port0", 64'(req_grant), 64'd1);
        @(negedge clk);
        chk("R3 then port1", 64'(req_grant), 64'd2);
        @(negedge clk);
        chk("R3 back to port0", 64'(req_grant), 64'd1);
        chk("R4 rsp for port0", 64'(rsp_port), 64'd0);
        @(negedge clk);
        req_valid = 2'b00;
        chk("R4 rsp for port1", 64'(rsp_port), 64'd1);
        chk("R4 rsp valid", 64'(rsp_valid), 64'd1);
        repeat (3) @(negedge clk);
        chk("R4 rsp drains", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 2'b00;
        req_dst = '0;
        req_src = '0;
        t_reset();
        t_round_robin();
        t_learn_decide();
        t_group();
        t_move();
        t_collision();
        t_self();
        t_back_to_back();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule